// File: doc/BRIEF.md
# Indexed Translation Buffer with Multi-Hit Shutdown

This block is a fully associative translation buffer of 48 slots. Each slot holds a virtual page-pair tag, an 8-bit address-space identifier, a global flag and a page-size mask. It also holds two physical frame words, one for the even page of the pair and one for the odd page. Each frame word carries a frame number, a cache attribute code, a dirty bit and a valid bit. Software loads one slot at a time. It presents an index value together with staged tag, mask and frame words, and the whole slot is replaced in one write.

A lookup port takes a virtual address and the current identifier. One cycle later it returns a hit flag and the selected frame word. If a lookup finds the same address in more than one slot, translation can no longer be trusted. The buffer then enters a shutdown state that suppresses every later hit, and only reset leaves that state. An index value that names no slot changes nothing and raises a flag instead.

Top module: `tlb_indexed`

## Requirements
- R1: After reset no slot is valid, so every lookup misses, and `shutdown`, `bad_index` and `rsp_valid` are 0.
- R2: A write goes to the slot numbered by the low six bits of `wr_index`. Bits above those six are ignored, so index 0x45 loads slot 5.
- R3: A write whose low six index bits are 48 or more changes no slot and sets `bad_index` on the following cycle. The next in-range write clears `bad_index`.
- R4: A lookup matches a slot when the address bits 31..13 equal the stored tag. Tag bits that are set in the slot's 12-bit mask (mask bit i covers tag bit i, that is address bit 13+i) are left out of the comparison.
- R5: A slot with the global flag clear matches only when its stored identifier equals `lk_asid`. A slot with the global flag set matches under any identifier.
- R6: The odd frame word is chosen when the address bit at position 12 + (number of ones in the slot's mask) is 1. Otherwise the even frame word is chosen. The mask is contiguous from bit 0.
- R7: On a hit the frame word is returned as stored: frame number in bits 24..5, cache attribute in bits 4..2, dirty in bit 1 and valid in bit 0. Attribute codes such as 2 (uncached), 3 (cacheable noncoherent) and 4..6 (coherent variants) pass through unchanged.
- R8: A lookup that matches two or more slots returns no hit, and `shutdown` is 1 in the same cycle as that response.
- R9: Once set, `shutdown` stays 1 and every later lookup misses. Only reset clears it.
- R10: `rsp_valid` and the result of a lookup appear one cycle after `lk_en`. A lookup issued in the same cycle as a write sees the slot contents from before that write.
- R11: Rewriting a slot replaces its old tag, so the old page no longer hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Commit staged slot contents |
| wr_index | input | 8 | Index value; the low six bits select the slot |
| wr_vpn2 | input | 19 | Staged virtual page-pair tag |
| wr_asid | input | 8 | Staged address-space identifier |
| wr_global | input | 1 | Staged global flag |
| wr_mask | input | 12 | Staged page-size mask |
| wr_even | input | 25 | Staged even-page frame word |
| wr_odd | input | 25 | Staged odd-page frame word |
| lk_en | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Current address-space identifier |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Exactly one slot matched and no shutdown |
| rsp_pfn | output | 20 | Frame number on hit |
| rsp_attr | output | 3 | Cache attribute code on hit |
| rsp_dirty | output | 1 | Dirty bit on hit |
| rsp_fvalid | output | 1 | Frame valid bit on hit |
| shutdown | output | 1 | Sticky multi-match state |
| bad_index | output | 1 | Last write named no slot |

## Verification
Two operations can fall in the same cycle: an indexed write and a lookup of the page that the write installs. The bench raises `wr_en` and `lk_en` on one clock edge, with the lookup aimed at the newly written tag. It expects a miss from that lookup and a hit from the lookup that follows. The multi-match case is then built from that same slot plus a second slot that shares its tag. That lookup must report no hit and raise `shutdown` in its own response cycle.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
   localparam int unsigned ATTR_W = 3;

   // cache attribute codes carried in each frame word
   typedef enum logic [ATTR_W-1:0] {
      CA_WT_NOALLOC   = 3'd0,
      CA_WT_ALLOC     = 3'd1,
      CA_UNCACHED     = 3'd2,
      CA_NONCOHERENT  = 3'd3,
      CA_EXCL         = 3'd4,
      CA_EXCL_ON_WR   = 3'd5,
      CA_UPDATE_ON_WR = 3'd6,
      CA_SPARE        = 3'd7
   } cache_attr_e;
endpackage

// File: rtl/tlbx_wdec.sv
module tlbx_wdec #(
   parameter int NUM_ENTRIES = 48,
   parameter int IDXREG_W    = 8,
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic                   wr_en,
   input  logic [IDXREG_W-1:0]    idx,
   output logic [NUM_ENTRIES-1:0] sel,
   output logic                   bad
);
   localparam logic [IDX_W:0] LIM = (IDX_W+1)'(NUM_ENTRIES);

   logic [IDX_W-1:0] idx_lo;
   assign idx_lo = idx[IDX_W-1:0];
   assign bad    = wr_en & ({1'b0, idx_lo} >= LIM);

   if (IDXREG_W > IDX_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^idx[IDXREG_W-1:IDX_W];
   end

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_sel
      assign sel[e] = wr_en & ~bad & (idx_lo == IDX_W'(e));
   end
endmodule

// File: rtl/tlbx_slot.sv
module tlbx_slot #(
   parameter int VA_W      = 32,
   parameter int PG_SHIFT  = 12,
   parameter int ASID_W    = 8,
   parameter int MASK_W    = 12,
   parameter int FRM_W     = 25,
   localparam int VPN2_W   = VA_W - PG_SHIFT - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sel,
   input  logic [VPN2_W-1:0] wr_vpn2,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_global,
   input  logic [MASK_W-1:0] wr_mask,
   input  logic [FRM_W-1:0]  wr_even,
   input  logic [FRM_W-1:0]  wr_odd,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              match,
   output logic [FRM_W-1:0]  frame
);
   logic              valid_q;
   logic [VPN2_W-1:0] vpn2_q;
   logic [ASID_W-1:0] asid_q;
   logic              glob_q;
   logic [MASK_W-1:0] mask_q;
   logic [FRM_W-1:0]  even_q;
   logic [FRM_W-1:0]  odd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      valid_q <= 1'b0;
      else if (wr_sel) valid_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_sel) begin
         vpn2_q <= wr_vpn2;
         asid_q <= wr_asid;
         glob_q <= wr_global;
         mask_q <= wr_mask;
         even_q <= wr_even;
         odd_q  <= wr_odd;
      end
   end

   logic [VPN2_W-1:0] ign;
   logic              tag_eq;
   logic              asid_ok;
   logic              odd_sel;

   always_comb begin
      ign     = {{(VPN2_W-MASK_W){1'b0}}, mask_q};
      tag_eq  = ((vpn2_q ^ lk_va[VA_W-1 -: VPN2_W]) & ~ign) == '0;
      asid_ok = glob_q | (asid_q == lk_asid);
      match   = valid_q & tag_eq & asid_ok;
      // highest set mask bit marks the page-size boundary
      odd_sel = lk_va[PG_SHIFT];
      for (int i = 0; i < MASK_W; i++) begin
         if (mask_q[i]) odd_sel = lk_va[PG_SHIFT+1+i];
      end
      frame = odd_sel ? odd_q : even_q;
   end

   logic unused_lo;
   assign unused_lo = ^lk_va[PG_SHIFT-1:0];
endmodule

// File: rtl/tlbx_merge.sv
module tlbx_merge #(
   parameter int NUM_ENTRIES = 48,
   parameter int FRM_W       = 25,
   parameter int MULTI_STYLE = 0
) (
   input  logic [NUM_ENTRIES-1:0]            match,
   input  logic [NUM_ENTRIES-1:0][FRM_W-1:0] frames,
   output logic                              any,
   output logic                              multi,
   output logic [FRM_W-1:0]                  frame
);
   assign any = |match;

   always_comb begin
      frame = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (match[i]) frame = frame | frames[i];
      end
   end

   if (MULTI_STYLE == 0) begin : g_lowbit
      localparam logic [NUM_ENTRIES-1:0] ONE = NUM_ENTRIES'(1);
      // clearing the lowest set bit leaves something only if two were set
      assign multi = |(match & (match - ONE));
   end else if (MULTI_STYLE == 1) begin : g_chain
      always_comb begin
         logic seen;
         seen  = 1'b0;
         multi = 1'b0;
         for (int i = 0; i < NUM_ENTRIES; i++) begin
            multi = multi | (seen & match[i]);
            seen  = seen | match[i];
         end
      end
   end else begin : g_bad_style
      $error("tlbx_merge: MULTI_STYLE must be 0 or 1");
   end
endmodule

// File: rtl/tlb_indexed.sv
module tlb_indexed
   import tlbx_pkg::*;
#(
   parameter int NUM_ENTRIES = 48,
   parameter int VA_W        = 32,
   parameter int PG_SHIFT    = 12,
   parameter int ASID_W      = 8,
   parameter int MASK_W      = 12,
   parameter int PFN_W       = 20,
   parameter int IDXREG_W    = 8,
   parameter int MULTI_STYLE = 0,
   parameter bit OUT_REG     = 1'b1,
   localparam int IDX_W      = $clog2(NUM_ENTRIES),
   localparam int VPN2_W     = VA_W - PG_SHIFT - 1,
   localparam int FRM_W      = PFN_W + ATTR_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDXREG_W-1:0] wr_index,
   input  logic [VPN2_W-1:0] wr_vpn2,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_global,
   input  logic [MASK_W-1:0] wr_mask,
   input  logic [FRM_W-1:0]  wr_even,
   input  logic [FRM_W-1:0]  wr_odd,
   input  logic              lk_en,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [PFN_W-1:0]  rsp_pfn,
   output logic [ATTR_W-1:0] rsp_attr,
   output logic              rsp_dirty,
   output logic              rsp_fvalid,
   output logic              shutdown,
   output logic              bad_index
);
   if (NUM_ENTRIES < 2) begin : g_chk_n
      $error("tlb_indexed: NUM_ENTRIES must be at least 2");
   end
   if (IDXREG_W < IDX_W) begin : g_chk_idx
      $error("tlb_indexed: IDXREG_W narrower than the slot index");
   end
   if (PG_SHIFT < 1 || MASK_W >= VPN2_W) begin : g_chk_va
      $error("tlb_indexed: page mask must be narrower than the page-pair tag");
   end

   logic [NUM_ENTRIES-1:0]            sel;
   logic                              bad;
   logic [NUM_ENTRIES-1:0]            match_v;
   logic [NUM_ENTRIES-1:0][FRM_W-1:0] frame_v;
   logic                              any_m;
   logic                              multi_m;
   logic [FRM_W-1:0]                  frame_or;

   tlbx_wdec #(
      .NUM_ENTRIES(NUM_ENTRIES),
      .IDXREG_W   (IDXREG_W)
   ) u_wdec (
      .wr_en(wr_en),
      .idx  (wr_index),
      .sel  (sel),
      .bad  (bad)
   );

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
      tlbx_slot #(
         .VA_W    (VA_W),
         .PG_SHIFT(PG_SHIFT),
         .ASID_W  (ASID_W),
         .MASK_W  (MASK_W),
         .FRM_W   (FRM_W)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_sel   (sel[e]),
         .wr_vpn2  (wr_vpn2),
         .wr_asid  (wr_asid),
         .wr_global(wr_global),
         .wr_mask  (wr_mask),
         .wr_even  (wr_even),
         .wr_odd   (wr_odd),
         .lk_va    (lk_va),
         .lk_asid  (lk_asid),
         .match    (match_v[e]),
         .frame    (frame_v[e])
      );
   end

   tlbx_merge #(
      .NUM_ENTRIES(NUM_ENTRIES),
      .FRM_W      (FRM_W),
      .MULTI_STYLE(MULTI_STYLE)
   ) u_merge (
      .match (match_v),
      .frames(frame_v),
      .any   (any_m),
      .multi (multi_m),
      .frame (frame_or)
   );

   logic shutdown_q;
   logic bad_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shutdown_q <= 1'b0;
         bad_q      <= 1'b0;
      end else begin
         if (lk_en && multi_m) shutdown_q <= 1'b1;
         if (wr_en)            bad_q      <= bad;
      end
   end

   assign shutdown  = shutdown_q;
   assign bad_index = bad_q;

   logic             hit_now;
   logic [FRM_W-1:0] frm_now;
   logic [FRM_W-1:0] frm_out;

   assign hit_now = lk_en & any_m & ~multi_m & ~shutdown_q;
   assign frm_now = hit_now ? frame_or : '0;

   if (OUT_REG) begin : g_oreg
      logic             vld_q;
      logic             hit_q;
      logic [FRM_W-1:0] frm_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            hit_q <= 1'b0;
            frm_q <= '0;
         end else begin
            vld_q <= lk_en;
            hit_q <= hit_now;
            frm_q <= frm_now;
         end
      end
      assign rsp_valid = vld_q;
      assign rsp_hit   = hit_q;
      assign frm_out   = frm_q;
   end else begin : g_ocomb
      assign rsp_valid = lk_en;
      assign rsp_hit   = hit_now;
      assign frm_out   = frm_now;
   end

   assign rsp_pfn    = frm_out[FRM_W-1 -: PFN_W];
   assign rsp_attr   = frm_out[ATTR_W+1:2];
   assign rsp_dirty  = frm_out[1];
   assign rsp_fvalid = frm_out[0];
endmodule

// File: rtl/tlb_indexed_chk.sv
module tlb_indexed_chk #(
   parameter int NUM_ENTRIES = 48,
   parameter int IDXREG_W    = 8,
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [IDXREG_W-1:0] wr_index,
   input logic                lk_en,
   input logic                rsp_valid,
   input logic                rsp_hit,
   input logic                shutdown,
   input logic                bad_index
);
   localparam logic [IDX_W:0] LIM = (IDX_W+1)'(NUM_ENTRIES);

   logic idx_ok;
   logic wrote_q;
   assign idx_ok = {1'b0, wr_index[IDX_W-1:0]} < LIM;

   if (IDXREG_W > IDX_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wr_index[IDXREG_W-1:IDX_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               wrote_q <= 1'b0;
      else if (wr_en && idx_ok) wrote_q <= 1'b1;
   end

   a_r1_hit_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> wrote_q);
   a_r3_bad_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !idx_ok) |=> bad_index);
   a_r3_good_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx_ok) |=> !bad_index);
   a_r8_no_hit_in_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> !shutdown);
   a_r8_shutdown_from_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shutdown) |-> $past(lk_en));
   a_r9_shutdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |=> shutdown);
   a_r10_hit_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);
endmodule

bind tlb_indexed tlb_indexed_chk #(
   .NUM_ENTRIES(NUM_ENTRIES),
   .IDXREG_W   (IDXREG_W)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_index (wr_index),
   .lk_en    (lk_en),
   .rsp_valid(rsp_valid),
   .rsp_hit  (rsp_hit),
   .shutdown (shutdown),
   .bad_index(bad_index)
);

// File: tb/test_tlb_indexed.sv
module test_tlb_indexed;
   import tlbx_pkg::*;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_index = '0;
   logic [18:0] wr_vpn2 = '0;
   logic [7:0]  wr_asid = '0;
   logic        wr_global = 1'b0;
   logic [11:0] wr_mask = '0;
   logic [24:0] wr_even = '0;
   logic [24:0] wr_odd = '0;
   logic        lk_en = 1'b0;
   logic [31:0] lk_va = '0;
   logic [7:0]  lk_asid = '0;
   logic        rsp_valid, rsp_hit, rsp_dirty, rsp_fvalid, shutdown, bad_index;
   logic [19:0] rsp_pfn;
   logic [2:0]  rsp_attr;

   always #(CLK_P/2) clk = ~clk;

   tlb_indexed i_tlb_indexed (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_index(wr_index), .wr_vpn2(wr_vpn2), .wr_asid(wr_asid),
      .wr_global(wr_global), .wr_mask(wr_mask), .wr_even(wr_even), .wr_odd(wr_odd),
      .lk_en(lk_en), .lk_va(lk_va), .lk_asid(lk_asid),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn), .rsp_attr(rsp_attr),
      .rsp_dirty(rsp_dirty), .rsp_fvalid(rsp_fvalid),
      .shutdown(shutdown), .bad_index(bad_index)
   );

   typedef struct {
      string       req;
      bit          hit;
      logic [24:0] frm;
      bit          sd;
   } exp_t;

   exp_t q[$];
   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [24:0] frm(input logic [19:0] p, input logic [2:0] a,
                                       input logic d, input logic v);
      return {p, a, d, v};
   endfunction

   function automatic logic [31:0] va_of(input logic [18:0] vpn2, input logic [12:0] lo);
      return {vpn2, lo};
   endfunction

   // monitor: pops one expectation per response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (q.size() == 0) begin
            chk(1'b0, "R10", "unexpected response", 64'(rsp_hit), 64'(0));
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(rsp_hit == e.hit, e.req, "hit", 64'(rsp_hit), 64'(e.hit));
            chk(shutdown == e.sd, e.req, "shutdown", 64'(shutdown), 64'(e.sd));
            if (e.hit)
               chk({rsp_pfn, rsp_attr, rsp_dirty, rsp_fvalid} == e.frm, e.req, "frame",
                   64'({rsp_pfn, rsp_attr, rsp_dirty, rsp_fvalid}), 64'(e.frm));
         end
      end
   end

   task automatic wr(input logic [7:0] idx, input logic [18:0] vpn2, input logic [7:0] asid,
                     input logic g, input logic [11:0] mask,
                     input logic [24:0] ev, input logic [24:0] od);
      wr_en = 1'b1; wr_index = idx; wr_vpn2 = vpn2; wr_asid = asid;
      wr_global = g; wr_mask = mask; wr_even = ev; wr_odd = od;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic lk(input logic [31:0] va, input logic [7:0] asid, input string req,
                     input bit hit, input logic [24:0] f, input bit sd);
      exp_t e;
      e.req = req; e.hit = hit; e.frm = f; e.sd = sd;
      q.push_back(e);
      lk_en = 1'b1; lk_va = va; lk_asid = asid;
      @(negedge clk);
      lk_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 20000);
      chk(1'b0, "R10", "watchdog expired", 64'(0), 64'(1));
      finish_run();
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1: reset state
      chk(shutdown == 1'b0, "R1", "shutdown after reset", 64'(shutdown), 64'(0));
      chk(bad_index == 1'b0, "R1", "bad_index after reset", 64'(bad_index), 64'(0));
      chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'(0));
      lk(va_of(19'h0, 13'h0), 8'h00, "R1", 1'b0, '0, 1'b0);
      lk(va_of(19'h10, 13'h0), 8'h11, "R1", 1'b0, '0, 1'b0);

      // R2: upper index bits ignored, 0x45 -> slot 5
      wr(8'h45, 19'h10, 8'h11, 1'b0, 12'h000,
         frm(20'hAAAAA, 3'(CA_NONCOHERENT), 1'b1, 1'b1),
         frm(20'hBBBBB, 3'(CA_UNCACHED), 1'b0, 1'b1));
      chk(bad_index == 1'b0, "R2", "bad_index after in-range write", 64'(bad_index), 64'(0));
      lk(va_of(19'h10, 13'h0000), 8'h11, "R2_R7",
         1'b1, frm(20'hAAAAA, 3'(CA_NONCOHERENT), 1'b1, 1'b1), 1'b0);
      // R6: bit 12 picks the odd page for a zero mask
      lk(va_of(19'h10, 13'h1000), 8'h11, "R6_R7",
         1'b1, frm(20'hBBBBB, 3'(CA_UNCACHED), 1'b0, 1'b1), 1'b0);
      // R5: wrong identifier on non-global slot
      lk(va_of(19'h10, 13'h0), 8'h12, "R5", 1'b0, '0, 1'b0);

      // R3: out-of-range indices
      wr(8'h30, 19'h20, 8'h11, 1'b1, 12'h000, frm(20'h12345, 3'd2, 1'b0, 1'b1), '0);
      chk(bad_index == 1'b1, "R3", "bad_index after index 48", 64'(bad_index), 64'(1));
      lk(va_of(19'h20, 13'h0), 8'h11, "R3", 1'b0, '0, 1'b0);
      wr(8'h3F, 19'h21, 8'h11, 1'b1, 12'h000, frm(20'h12345, 3'd2, 1'b0, 1'b1), '0);
      chk(bad_index == 1'b1, "R3", "bad_index after index 63", 64'(bad_index), 64'(1));
      lk(va_of(19'h21, 13'h0), 8'h11, "R3", 1'b0, '0, 1'b0);
      // slot 47 global, clears bad_index
      wr(8'h2F, 19'h30, 8'h55, 1'b1, 12'h000,
         frm(20'h47474, 3'(CA_EXCL), 1'b1, 1'b0), frm(20'h47475, 3'd1, 1'b0, 1'b1));
      chk(bad_index == 1'b0, "R3", "bad_index cleared by slot 47", 64'(bad_index), 64'(0));
      lk(va_of(19'h30, 13'h0), 8'h99, "R5", 1'b1, frm(20'h47474, 3'(CA_EXCL), 1'b1, 1'b0), 1'b0);

      // R4/R6: mask 0x003 on slot 10
      wr(8'h0A, 19'h100, 8'h11, 1'b0, 12'h003,
         frm(20'h11111, 3'(CA_EXCL_ON_WR), 1'b0, 1'b1),
         frm(20'h22222, 3'(CA_UPDATE_ON_WR), 1'b1, 1'b1));
      lk(va_of(19'h101, 13'h0), 8'h11, "R4", 1'b1,
         frm(20'h11111, 3'(CA_EXCL_ON_WR), 1'b0, 1'b1), 1'b0);
      lk(va_of(19'h100, 13'h1000), 8'h11, "R6", 1'b1,
         frm(20'h11111, 3'(CA_EXCL_ON_WR), 1'b0, 1'b1), 1'b0);
      lk(va_of(19'h102, 13'h0), 8'h11, "R6", 1'b1,
         frm(20'h22222, 3'(CA_UPDATE_ON_WR), 1'b1, 1'b1), 1'b0);
      lk(va_of(19'h104, 13'h0), 8'h11, "R4", 1'b0, '0, 1'b0);

      // R11: rewrite slot 5 with plain index
      wr(8'h05, 19'h11, 8'h11, 1'b0, 12'h000, frm(20'hCCCCC, 3'd3, 1'b0, 1'b1), '0);
      lk(va_of(19'h10, 13'h0), 8'h11, "R11", 1'b0, '0, 1'b0);
      lk(va_of(19'h11, 13'h0), 8'h11, "R11", 1'b1, frm(20'hCCCCC, 3'd3, 1'b0, 1'b1), 1'b0);

      // R10: write and lookup in the same cycle
      begin
         exp_t e;
         e.req = "R10"; e.hit = 1'b0; e.frm = '0; e.sd = 1'b0;
         q.push_back(e);
         wr_en = 1'b1; wr_index = 8'd20; wr_vpn2 = 19'h200; wr_asid = 8'h33;
         wr_global = 1'b1; wr_mask = 12'h000;
         wr_even = frm(20'h20202, 3'd3, 1'b1, 1'b1); wr_odd = '0;
         lk_en = 1'b1; lk_va = va_of(19'h200, 13'h0); lk_asid = 8'h33;
         @(negedge clk);
         wr_en = 1'b0; lk_en = 1'b0;
      end
      lk(va_of(19'h200, 13'h0), 8'h55, "R10", 1'b1, frm(20'h20202, 3'd3, 1'b1, 1'b1), 1'b0);

      // R8: second slot with same tag -> multi-match
      wr(8'd30, 19'h200, 8'h44, 1'b0, 12'h000, frm(20'h30303, 3'd2, 1'b0, 1'b1), '0);
      lk(va_of(19'h200, 13'h0), 8'h55, "R8", 1'b1, frm(20'h20202, 3'd3, 1'b1, 1'b1), 1'b0);
      lk(va_of(19'h200, 13'h0), 8'h44, "R8", 1'b0, '0, 1'b1);
      // R9: sticky, later single matches suppressed
      lk(va_of(19'h30, 13'h0), 8'h99, "R9", 1'b0, '0, 1'b1);
      idle(5);
      chk(shutdown == 1'b1, "R9", "shutdown held", 64'(shutdown), 64'(1));
      lk(va_of(19'h11, 13'h0), 8'h11, "R9", 1'b0, '0, 1'b1);
      idle(2);

      // R9/R1: reset clears shutdown and slots
      do_reset();
      chk(shutdown == 1'b0, "R9", "shutdown after reset", 64'(shutdown), 64'(0));
      lk(va_of(19'h30, 13'h0), 8'h99, "R1", 1'b0, '0, 1'b0);
      idle(2);
      chk(q.size() == 0, "R10", "responses outstanding", 64'(q.size()), 64'(0));
      finish_run();
   end
endmodule